// File: doc/BRIEF.md
# Windowless Watchdog Timer

This peripheral is a watchdog for a slow clock domain of roughly 32 kHz. A prescaler turns the slow clock into a half-second tick. A down-counter, loaded from an 8-bit timeout field, counts those ticks. Software keeps the counter from running out by writing a two-word key into the service register. Once the timer is started it cannot be stopped. When the count reaches zero, a mode bit selects one of two actions: raise the internal reset request, or pull the active-low external reset pin.

Software works through five 16-bit registers on a simple offset/write-enable bus. The read data is combinational.
- A pre-timeout interrupt can be set up to fire a chosen number of half-seconds before expiry.
- Software can command a reset itself, but only with a doubled write.
- A sticky status word records the cause of the last reset.
- After power-on, a power-down counter emits a single low pulse on the interrupt line unless software disarms it in time.

Top module: `wdog16`

## Requirements
- R1: After `rst_n`:
  - the control register (offset 0x00) reads 0x0030;
  - reset status (0x04) and interrupt control (0x06) read 0x0000;
  - the miscellaneous register (0x08) reads 0x0001;
  - `int_rst_req` is 0, and `ext_rst_n` and `irq_n` are 1.
- R2: A control write with bit 2 set starts the timer when it is stopped, loading N+1 half-seconds from timeout field bits 15:8 = N. One half-second is TICK_DIV clocks. Expiry comes (N+1)*TICK_DIV clocks after the starting write edge, and counting stops.
- R3: Control bit 2 (enable) and bit 0 (suspend) can only be set. Writing 0 to either leaves it at 1.
- R4: Writing 0x5555 and then 0xAAAA to offset 0x02, with no other service-register write between them, reloads the counter to N+1 half-seconds and restarts the half-second phase. Any other sequence leaves the count untouched. A new timeout field written while running is used only from the next reload.
- R5: On expiry, control bit 3 selects the action.
  - When bit 3 = 0, `int_rst_req` goes high and stays high, and `ext_rst_n` is unaffected.
  - When bit 3 = 1, `ext_rst_n` goes low and stays low, and `int_rst_req` stays low.
- R6: A control write with bit 4 = 0 asserts `int_rst_req` (sticky) only if a previous such write came at most SRS_WIN clocks earlier. A lone write has no effect. Control bit 5 written as 0 drives `ext_rst_n` low.
- R7: While suspend (control bit 0) is set and `lp_mode` is high, the count and the half-second phase hold.
- R8: Interrupt control (0x06) uses three fields:
  - bit 14 becomes 1 on the tick that leaves exactly bits 7:0 half-seconds remaining;
  - while bit 15 and bit 14 are both 1, `irq_n` is low;
  - writing 1 to bit 14 clears it.
- R9: Reset status (0x04) reports the cause of a reset. Bit 1 is set by a watchdog expiry and bit 0 by a software reset. Both stay set until `rst_n`.
- R10: Unless a write of bit 0 = 0 to offset 0x08 comes first, `irq_n` pulses low for exactly one clock PD_HALFSEC*TICK_DIV clocks after reset. Offset 0x08 bit 0 reads 1 while this counter is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| lp_mode | input | 1 | Low-power state indication |
| addr | input | 4 | Register byte offset |
| wr_en | input | 1 | Write strobe |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` (combinational) |
| int_rst_req | output | 1 | Internal reset request, active high |
| ext_rst_n | output | 1 | External reset pin, active low |
| irq_n | output | 1 | Interrupt line, active low |

## Verification
The bench builds the block with TICK_DIV=4, PD_HALFSEC=8 and SRS_WIN=3. With these values a half-second is four clocks and the power-down pulse lands 32 clocks after reset. This makes it practical to check every expiry, reload, pre-timeout and suspend case on exact clock edges. The same short settings put both edges of the software-reset window within a few writes, so the lone write and the doubled write can each be tested.

// File: rtl/wdog16.sv
module wdog16 #(
  parameter int TICK_DIV   = 16384,
  parameter int PD_HALFSEC = 16,
  parameter int SRS_WIN    = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        lp_mode,
  input  logic [3:0]  addr,
  input  logic        wr_en,
  input  logic [15:0] wdata,
  output logic [15:0] rdata,
  output logic        int_rst_req,
  output logic        ext_rst_n,
  output logic        irq_n
);

  localparam int PW     = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int PD_CYC = PD_HALFSEC * TICK_DIV;
  localparam int DW     = $clog2(PD_CYC + 1);
  localparam int SW     = $clog2(SRS_WIN + 1);
  localparam logic [PW-1:0] PRE_LAST = PW'(TICK_DIV - 1);
  localparam logic [3:0] A_CTRL = 4'h0, A_SVC = 4'h2, A_STAT = 4'h4, A_ICR = 4'h6, A_MISC = 4'h8;

  logic [7:0]    tout, wict;
  logic          ext_bit, sel, en, susp, swr, armed, expired;
  logic          wie, sts, pd_en, pd_pulse, rs_tout, rs_sw;
  logic [8:0]    cnt;
  logic [PW-1:0] pre;
  logic [DW-1:0] pd_cnt;
  logic [SW-1:0] srs_t;

  wire wr_ctrl = wr_en && addr == A_CTRL;
  wire wr_svc  = wr_en && addr == A_SVC;
  wire wr_icr  = wr_en && addr == A_ICR;
  wire wr_misc = wr_en && addr == A_MISC;

  wire run     = en && !expired && !(susp && lp_mode);
  wire tick    = run && pre == PRE_LAST;
  wire start   = wr_ctrl && wdata[2] && !en;
  wire svc_ok  = wr_svc && wdata == 16'hAAAA && armed && en && !expired;
  wire [7:0] tout_nx = wr_ctrl ? wdata[15:8] : tout;
  wire srs_hit = wr_ctrl && !wdata[4];
  wire fire    = tick && cnt == 9'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tout <= '0; ext_bit <= 1'b1; sel <= 1'b0; en <= 1'b0; susp <= 1'b0;
    end else if (wr_ctrl) begin
      tout    <= wdata[15:8];
      ext_bit <= wdata[5];
      sel     <= wdata[3];
      en      <= en | wdata[2];
      susp    <= susp | wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; pre <= '0; expired <= 1'b0;
    end else begin
      if (start || svc_ok) begin
        cnt <= {1'b0, tout_nx} + 9'd1;
        pre <= '0;
      end else if (tick) begin
        cnt <= cnt - 9'd1;
        pre <= '0;
      end else if (run) begin
        pre <= pre + 1'b1;
      end
      if (fire) expired <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else if (wr_svc) armed <= (wdata == 16'h5555);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      swr <= 1'b0; srs_t <= '0;
    end else if (srs_hit && srs_t != '0) begin
      swr <= 1'b1; srs_t <= '0;
    end else if (srs_hit) begin
      srs_t <= SW'(SRS_WIN);
    end else if (srs_t != '0) begin
      srs_t <= srs_t - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wie <= 1'b0; wict <= '0; sts <= 1'b0;
    end else begin
      if (wr_icr) begin
        wie  <= wdata[15];
        wict <= wdata[7:0];
      end
      if (tick && (cnt - 9'd1) == {1'b0, wict}) sts <= 1'b1;
      else if (wr_icr && wdata[14]) sts <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_tout <= 1'b0; rs_sw <= 1'b0;
    end else begin
      if (fire) rs_tout <= 1'b1;
      if (srs_hit && srs_t != '0) rs_sw <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pd_en <= 1'b1; pd_cnt <= DW'(PD_CYC); pd_pulse <= 1'b0;
    end else begin
      pd_pulse <= 1'b0;
      if (pd_en) begin
        if (wr_misc && !wdata[0]) begin
          pd_en <= 1'b0;
        end else if (pd_cnt == DW'(1)) begin
          pd_pulse <= 1'b1;
          pd_en    <= 1'b0;
        end else begin
          pd_cnt <= pd_cnt - 1'b1;
        end
      end
    end
  end

  always_comb begin
    case (addr)
      A_CTRL:  rdata = {tout, 2'b00, ext_bit, ~swr, sel, en, 1'b0, susp};
      A_STAT:  rdata = {14'd0, rs_tout, rs_sw};
      A_ICR:   rdata = {wie, sts, 6'd0, wict};
      A_MISC:  rdata = {15'd0, pd_en};
      default: rdata = 16'd0;
    endcase
  end

  assign int_rst_req = (expired && !sel) || swr;
  assign ext_rst_n   = ext_bit && !(expired && sel);
  assign irq_n       = !((wie && sts) || pd_pulse);

endmodule

// File: rtl/wdog16_chk.sv
module wdog16_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       lp_mode,
  input logic [3:0] addr,
  input logic       wr_en,
  input logic [15:0] wdata,
  input logic       en,
  input logic       susp,
  input logic       armed,
  input logic       expired,
  input logic       swr,
  input logic       pd_pulse,
  input logic [8:0] cnt,
  input logic [7:0] tout,
  input logic       int_rst_req
);

  a_r3_enable_holds: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> en);

  a_r3_suspend_holds: assert property (@(posedge clk) disable iff (!rst_n)
    susp |=> susp);

  a_r2_idle_never_expires: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !expired);

  a_r4_key_reloads: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 4'h2 && wdata == 16'hAAAA && armed && en && !expired)
      |=> cnt == {1'b0, $past(tout)} + 9'd1);

  a_r7_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (en && susp && lp_mode && !(wr_en && addr == 4'h2)) |=> $stable(cnt));

  a_r5_expiry_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    expired |=> expired);

  a_r6_swreset_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    swr |=> int_rst_req);

  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    pd_pulse |=> !pd_pulse);

endmodule

bind wdog16 wdog16_chk u_chk (
  .clk(clk), .rst_n(rst_n), .lp_mode(lp_mode), .addr(addr), .wr_en(wr_en),
  .wdata(wdata), .en(en), .susp(susp), .armed(armed), .expired(expired),
  .swr(swr), .pd_pulse(pd_pulse), .cnt(cnt), .tout(tout),
  .int_rst_req(int_rst_req)
);

// File: tb/wdog16_bench.sv
module wdog16_bench;
  localparam int DIV = 4, PDH = 8, SWIN = 3;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n = 1'b0, lp_mode = 1'b0, wr_en = 1'b0;
  logic [3:0]  addr = 4'h0;
  logic [15:0] wdata = 16'h0;
  logic [15:0] rdata;
  logic        int_rst_req, ext_rst_n, irq_n;

  wdog16 #(.TICK_DIV(DIV), .PD_HALFSEC(PDH), .SRS_WIN(SWIN)) u_wdog16 (
    .clk(clk), .rst_n(rst_n), .lp_mode(lp_mode), .addr(addr), .wr_en(wr_en),
    .wdata(wdata), .rdata(rdata), .int_rst_req(int_rst_req),
    .ext_rst_n(ext_rst_n), .irq_n(irq_n));

  int errs = 0, checks = 0, cyc = 0, irq_lows = 0;
  string phase = "R1";
  bit cmp_on = 0, rst_seen = 0, done = 0;

  // behavioural reference state
  int m_wt, m_ext, m_sel, m_en, m_susp, m_swr, m_win, m_cnt, m_pre, m_exp, m_arm;
  int m_wie, m_sts, m_wict, m_pden, m_pdc, m_pdp, m_rst, m_rsw;
  int o_cnt, o_exp, run, tick, wc, ws, wi, wm;

  always @(posedge clk) begin
    cyc++;
    rst_seen = rst_n;
    if (!rst_n) begin
      m_wt = 0; m_ext = 1; m_sel = 0; m_en = 0; m_susp = 0; m_swr = 0; m_win = 0;
      m_cnt = 0; m_pre = 0; m_exp = 0; m_arm = 0; m_wie = 0; m_sts = 0; m_wict = 0;
      m_pden = 1; m_pdc = PDH * DIV; m_pdp = 0; m_rst = 0; m_rsw = 0;
    end else begin
      wc = int'(wr_en && addr == 4'h0);
      ws = int'(wr_en && addr == 4'h2);
      wi = int'(wr_en && addr == 4'h6);
      wm = int'(wr_en && addr == 4'h8);
      o_cnt = m_cnt; o_exp = m_exp;
      run  = int'(m_en != 0 && o_exp == 0 && !(m_susp != 0 && lp_mode));
      tick = int'(run != 0 && m_pre == DIV - 1);
      if (tick != 0 && o_cnt - 1 == m_wict) m_sts = 1;
      else if (wi != 0 && wdata[14]) m_sts = 0;
      if (tick != 0 && o_cnt == 1) begin m_exp = 1; m_rst = 1; end
      if (wc != 0 && wdata[2] && m_en == 0) begin
        m_cnt = int'(wdata[15:8]) + 1; m_pre = 0;
      end else if (ws != 0 && wdata == 16'hAAAA && m_arm != 0 && m_en != 0 && o_exp == 0) begin
        m_cnt = m_wt + 1; m_pre = 0;
      end else if (tick != 0) begin
        m_cnt = o_cnt - 1; m_pre = 0;
      end else if (run != 0) begin
        m_pre = m_pre + 1;
      end
      if (ws != 0) m_arm = int'(wdata == 16'h5555);
      if (wc != 0 && !wdata[4]) begin
        if (m_win > 0) begin m_swr = 1; m_rsw = 1; m_win = 0; end
        else m_win = SWIN;
      end else if (m_win > 0) m_win--;
      if (wc != 0) begin
        m_wt = int'(wdata[15:8]); m_ext = int'(wdata[5]); m_sel = int'(wdata[3]);
        if (wdata[2]) m_en = 1;
        if (wdata[0]) m_susp = 1;
      end
      if (wi != 0) begin m_wie = int'(wdata[15]); m_wict = int'(wdata[7:0]); end
      m_pdp = 0;
      if (m_pden != 0) begin
        if (wm != 0 && !wdata[0]) m_pden = 0;
        else if (m_pdc == 1) begin m_pdp = 1; m_pden = 0; end
        else m_pdc--;
      end
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (cmp_on && rst_seen && rst_n && !done) begin
      chk({phase, " int_rst_req"}, {15'd0, int_rst_req},
          {15'd0, ((m_exp != 0 && m_sel == 0) || m_swr != 0)});
      chk({phase, " ext_rst_n"}, {15'd0, ext_rst_n},
          {15'd0, (m_ext != 0 && !(m_exp != 0 && m_sel != 0))});
      chk({phase, " irq_n"}, {15'd0, irq_n},
          {15'd0, !((m_wie != 0 && m_sts != 0) || m_pdp != 0)});
      if (!irq_n) irq_lows++;
    end
  end

  task automatic summary();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc > 20000 && !done) begin
      errs++;
      $display("FAIL watchdog: actual=hung expected=finished in phase %s", phase);
      summary();
    end
  end

  task automatic do_reset();
    @(negedge clk); #1 rst_n = 1'b0; wr_en = 1'b0; lp_mode = 1'b0;
    repeat (2) @(negedge clk);
    #1 rst_n = 1'b1;
    irq_lows = 0;
    cmp_on = 1;
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [15:0] exp, input string tag);
    @(negedge clk); addr = a; #1 chk(tag, rdata, exp);
  endtask

  // measures clocks from the current edge until the chosen output event
  task automatic measure(input int which, output int n);
    int t0 = cyc;
    n = -1;
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      if ((which == 0 && int_rst_req) || (which == 1 && !ext_rst_n) ||
          (which == 2 && !irq_n)) begin
        n = cyc - t0; break;
      end
    end
  endtask

  int n;

  initial begin
    // R1 reset values, R10 power-down pulse
    phase = "R1";
    do_reset();
    chk("R1 outputs", {13'd0, int_rst_req, ext_rst_n, irq_n}, 16'h0003);
    rd(4'h0, 16'h0030, "R1 ctrl");
    rd(4'h4, 16'h0000, "R1 status");
    rd(4'h6, 16'h0000, "R1 icr");
    rd(4'h8, 16'h0001, "R1 misc");
    phase = "R10";
    repeat (40) @(negedge clk);
    chk("R10 one low pulse", 16'(irq_lows), 16'd1);
    rd(4'h8, 16'h0000, "R10 misc after pulse");

    // R10 disarm
    do_reset();
    wr(4'h8, 16'h0000);
    repeat (40) @(negedge clk);
    chk("R10 disarmed no pulse", 16'(irq_lows), 16'd0);
    rd(4'h8, 16'h0000, "R10 misc disarmed");

    // R2/R5/R9 internal expiry
    phase = "R2";
    do_reset();
    wr(4'h8, 16'h0000);
    wr(4'h0, 16'h0334);
    repeat (15) @(negedge clk);
    chk("R2 not yet expired", {15'd0, int_rst_req}, 16'd0);
    @(negedge clk);
    chk("R2 expired at 16", {15'd0, int_rst_req}, 16'd1);
    chk("R5 ext untouched", {15'd0, ext_rst_n}, 16'd1);
    rd(4'h4, 16'h0002, "R9 timeout cause");

    // R4 bad key, good key, new timeout at reload
    phase = "R4";
    do_reset();
    wr(4'h8, 16'h0000);
    wr(4'h0, 16'h0334);
    wr(4'h2, 16'h5555);
    wr(4'h2, 16'h1234);
    wr(4'h2, 16'hAAAA);
    measure(0, n);
    chk("R4 broken key no reload", 16'(n), 16'd10);
    do_reset();
    wr(4'h8, 16'h0000);
    wr(4'h0, 16'h0334);
    repeat (6) @(negedge clk);
    wr(4'h2, 16'h5555);
    wr(4'h2, 16'hAAAA);
    measure(0, n);
    chk("R4 key reloads 16", 16'(n), 16'd16);
    do_reset();
    wr(4'h8, 16'h0000);
    wr(4'h0, 16'h0334);
    wr(4'h0, 16'h0134);
    wr(4'h2, 16'h5555);
    wr(4'h2, 16'hAAAA);
    measure(0, n);
    chk("R4 new field at reload", 16'(n), 16'd8);

    // R3 write-once bits, R7 suspend
    phase = "R3";
    do_reset();
    wr(4'h8, 16'h0000);
    wr(4'h0, 16'h0335);
    wr(4'h0, 16'h0330);
    rd(4'h0, 16'h0335, "R3 enable and suspend kept");
    phase = "R7";
    lp_mode = 1'b1;
    repeat (40) @(negedge clk);
    chk("R7 held in low power", {15'd0, int_rst_req}, 16'd0);
    lp_mode = 1'b0;
    measure(0, n);
    chk("R7 resumes and expires", {15'd0, int_rst_req}, 16'd1);

    // R5 external mode
    phase = "R5";
    do_reset();
    wr(4'h8, 16'h0000);
    wr(4'h0, 16'h033C);
    measure(1, n);
    chk("R5 ext pin at 16", 16'(n), 16'd16);
    chk("R5 internal stays low", {15'd0, int_rst_req}, 16'd0);

    // R8 pre-timeout interrupt
    phase = "R8";
    do_reset();
    wr(4'h8, 16'h0000);
    wr(4'h6, 16'h8002);
    wr(4'h0, 16'h0734);
    measure(2, n);
    chk("R8 irq 2 half-s early", 16'(n), 16'd24);
    rd(4'h6, 16'hC002, "R8 status set");
    wr(4'h6, 16'hC002);
    chk("R8 cleared irq", {15'd0, irq_n}, 16'd1);
    rd(4'h6, 16'h8002, "R8 status cleared");

    // R6 software reset, R9 cause
    phase = "R6";
    do_reset();
    wr(4'h8, 16'h0000);
    wr(4'h0, 16'h0020);
    repeat (6) @(negedge clk);
    chk("R6 lone write ignored", {15'd0, int_rst_req}, 16'd0);
    wr(4'h0, 16'h0020);
    wr(4'h0, 16'h0020);
    chk("R6 doubled write resets", {15'd0, int_rst_req}, 16'd1);
    rd(4'h4, 16'h0001, "R9 software cause");
    wr(4'h0, 16'h0010);
    chk("R6 ext bit low", {15'd0, ext_rst_n}, 16'd0);
    repeat (4) @(negedge clk);
    rd(4'h4, 16'h0001, "R9 cause sticky");

    summary();
  end
endmodule